// File: doc/BRIEF.md
# Microcoded Control Sequencer with Opcode Dispatch

This block is the control unit of a multi-cycle processor in microcoded form. A 4-bit micro-program counter addresses a control store of sixteen words, ten of which are live. Each word carries a 16-bit datapath control vector and a 2-bit sequencing code. The control vector goes straight to the datapath, so it depends on the current micro-address and on nothing else. The sequencing code tells the address-select logic where to go next.

There are four ways to pick the next micro-address: return to the fetch word (address 0), step to the address plus one, or jump through one of two lookup tables indexed by the instruction opcode. The first table splits instruction types after decode. The second table splits loads from stores after the address calculation. An opcode that has no entry in the table being consulted sends the sequencer back to fetch, so it can never hang. No per-state next-state table is needed.

Top module: `microseq_ctrl`

## Requirements
- R1: With `rst` high at a rising clock edge, `upc_o` becomes 0 at that edge (synchronous reset). After reset, `ctrl_o` shows the fetch word 0x9410.
- R2: Micro-address 0 uses code 3 (step): it always goes to 1, and so do 3 to 4 and 6 to 7, whatever the opcode.
- R3: At micro-address 1 (code 1, first table), the next address is 6 for opcode 000000, 9 for 000010, 8 for 000100, and 2 for both 100011 and 101011.
- R4: At micro-address 2 (code 2, second table), the next address is 3 for opcode 100011 and 5 for opcode 101011.
- R5: Micro-addresses 4, 5, 7, 8 and 9 use code 0 and return to 0 on the next edge.
- R6: In a table dispatch, an opcode with no table entry sets the next micro-address to 0.
- R7: `ctrl_o` is bit 15 PC write, 14 PC write on zero, 13 memory address from ALU register, 12 memory read, 11 memory write, 10 instruction register write, 9 register data from memory data register, 8 register write, 7 destination from rd field, 6 first ALU operand from register A, 5:4 second operand select (0 B, 1 constant 4, 2 sign-extended immediate, 3 shifted immediate), 3:2 ALU mode (0 add, 1 subtract, 2 function code), 1:0 PC source (0 ALU, 1 ALU register, 2 jump target). The words for addresses 0 to 9 are 0x9410, 0x0030, 0x0060, 0x3000, 0x0300, 0x2800, 0x0048, 0x0180, 0x4045, 0x8002.
- R8: `ctrl_o` changes only when `upc_o` changes. A change of `opcode_i` within a cycle leaves it unchanged.
- R9: `upc_o` never leaves the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode_i | input | 6 | Opcode field of the held instruction |
| upc_o | output | 4 | Current micro-program counter |
| ctrl_o | output | 16 | Datapath control vector of the current micro-word |

## Verification
The assertions assume `opcode_i` is a settled value at each rising edge. They also assume reset is held for at least two edges, so the stability check on `ctrl_o` never compares against a pre-reset unknown. The bench changes the opcode only a few nanoseconds after an edge and holds reset for three cycles. Some walks change the opcode between micro-steps on purpose, for example to a type that is not a load or store just before the second dispatch. This reaches the miss path of the second table, which an instruction held steady cannot reach.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UPC_W  = 4;
  localparam int OP_W   = 6;
  localparam int CTRL_W = 16;
  localparam int SEQ_W  = 2;
  localparam int LIVE_WORDS = 10;

  typedef enum logic [SEQ_W-1:0] {
    SQ_FETCH = 2'd0,
    SQ_TAB1  = 2'd1,
    SQ_TAB2  = 2'd2,
    SQ_NEXT  = 2'd3
  } seq_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_zero;
    logic       maddr_alu;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       wb_from_mdr;
    logic       reg_wr;
    logic       dst_rd;
    logic       opa_reg;
    logic [1:0] opb_sel;
    logic [1:0] alu_mode;
    logic [1:0] pc_src;
  } ctrl_t;

  typedef struct packed {
    ctrl_t ctl;
    seq_e  seq;
  } uword_t;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;

  // Micro-word for each address; unused addresses fall back to fetch.
  function automatic uword_t uword_of(input logic [UPC_W-1:0] a);
    uword_t w;
    w     = '0;
    w.seq = SQ_FETCH;
    case (a)
      4'd0: begin  // fetch, PC += 4
        w.ctl.mem_rd = 1'b1; w.ctl.ir_wr = 1'b1; w.ctl.pc_wr = 1'b1;
        w.ctl.opb_sel = 2'd1; w.seq = SQ_NEXT;
      end
      4'd1: begin  // decode, branch target precompute
        w.ctl.opb_sel = 2'd3; w.seq = SQ_TAB1;
      end
      4'd2: begin  // memory address
        w.ctl.opa_reg = 1'b1; w.ctl.opb_sel = 2'd2; w.seq = SQ_TAB2;
      end
      4'd3: begin  // load read
        w.ctl.mem_rd = 1'b1; w.ctl.maddr_alu = 1'b1; w.seq = SQ_NEXT;
      end
      4'd4: begin  // load write-back
        w.ctl.reg_wr = 1'b1; w.ctl.wb_from_mdr = 1'b1;
      end
      4'd5: begin  // store write
        w.ctl.mem_wr = 1'b1; w.ctl.maddr_alu = 1'b1;
      end
      4'd6: begin  // register-register execute
        w.ctl.opa_reg = 1'b1; w.ctl.alu_mode = 2'd2; w.seq = SQ_NEXT;
      end
      4'd7: begin  // register-register write-back
        w.ctl.reg_wr = 1'b1; w.ctl.dst_rd = 1'b1;
      end
      4'd8: begin  // branch compare
        w.ctl.opa_reg = 1'b1; w.ctl.alu_mode = 2'd1;
        w.ctl.pc_wr_zero = 1'b1; w.ctl.pc_src = 2'd1;
      end
      4'd9: begin  // jump
        w.ctl.pc_wr = 1'b1; w.ctl.pc_src = 2'd2;
      end
      default: ;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  logic [AW-1:0] addr_i,
  output ctrl_t         ctl_o,
  output seq_e          seq_o
);
  localparam int DEPTH = 1 << AW;

  uword_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = uword_of(UPC_W'(i));
  end

  assign ctl_o = rom[addr_i].ctl;
  assign seq_o = rom[addr_i].seq;
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int AW = UPC_W,
  parameter int OW = OP_W
) (
  input  logic [OW-1:0] opcode_i,
  output logic [AW-1:0] tab1_addr_o,
  output logic          tab1_hit_o,
  output logic [AW-1:0] tab2_addr_o,
  output logic          tab2_hit_o
);
  // First table: instruction class after decode.
  always_comb begin
    tab1_hit_o  = 1'b1;
    tab1_addr_o = '0;
    case (opcode_i)
      OPC_RTYPE: tab1_addr_o = AW'(6);
      OPC_JUMP:  tab1_addr_o = AW'(9);
      OPC_BEQ:   tab1_addr_o = AW'(8);
      OPC_LOAD,
      OPC_STORE: tab1_addr_o = AW'(2);
      default:   tab1_hit_o  = 1'b0;
    endcase
  end

  // Second table: load versus store after address calculation.
  always_comb begin
    tab2_hit_o  = 1'b1;
    tab2_addr_o = '0;
    case (opcode_i)
      OPC_LOAD:  tab2_addr_o = AW'(3);
      OPC_STORE: tab2_addr_o = AW'(5);
      default:   tab2_hit_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] upc_i,
  input  seq_e          seq_i,
  input  logic [AW-1:0] tab1_addr_i,
  input  logic          tab1_hit_i,
  input  logic [AW-1:0] tab2_addr_i,
  input  logic          tab2_hit_i,
  output logic [AW-1:0] nxt_o
);
  logic [AW-1:0] incr;

  assign incr = upc_i + AW'(1);

  always_comb begin
    unique case (seq_i)
      SQ_FETCH: nxt_o = '0;
      SQ_TAB1:  nxt_o = tab1_hit_i ? tab1_addr_i : '0;
      SQ_TAB2:  nxt_o = tab2_hit_i ? tab2_addr_i : '0;
      SQ_NEXT:  nxt_o = incr;
      default:  nxt_o = '0;
    endcase
  end

  // R6: a table miss in either dispatch lands on fetch
  a_r6_miss_to_fetch: assert property (@(posedge clk) disable iff (rst)
    ((seq_i == SQ_TAB1 && !tab1_hit_i) || (seq_i == SQ_TAB2 && !tab2_hit_i))
      |-> nxt_o == '0);
endmodule

// File: rtl/microseq_ctrl.sv
module microseq_ctrl
  import useq_pkg::*;
#(
  parameter int AW = UPC_W,
  parameter int OW = OP_W,
  parameter int CW = CTRL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] opcode_i,
  output logic [AW-1:0] upc_o,
  output logic [CW-1:0] ctrl_o
);
  logic [AW-1:0] upc_q, upc_d;
  ctrl_t         ctl;
  seq_e          seq;
  logic [AW-1:0] t1_addr, t2_addr;
  logic          t1_hit, t2_hit;

  useq_store #(.AW(AW)) u_store (
    .addr_i (upc_q),
    .ctl_o  (ctl),
    .seq_o  (seq)
  );

  useq_dispatch #(.AW(AW), .OW(OW)) u_disp (
    .opcode_i    (opcode_i),
    .tab1_addr_o (t1_addr),
    .tab1_hit_o  (t1_hit),
    .tab2_addr_o (t2_addr),
    .tab2_hit_o  (t2_hit)
  );

  useq_next #(.AW(AW)) u_next (
    .clk         (clk),
    .rst         (rst),
    .upc_i       (upc_q),
    .seq_i       (seq),
    .tab1_addr_i (t1_addr),
    .tab1_hit_i  (t1_hit),
    .tab2_addr_i (t2_addr),
    .tab2_hit_i  (t2_hit),
    .nxt_o       (upc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) upc_q <= '0;
    else     upc_q <= upc_d;
  end

  assign upc_o  = upc_q;
  assign ctrl_o = CW'(ctl);

  // R1
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> upc_q == '0);
  // R2
  a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
    upc_q == AW'(0) |=> upc_q == AW'(1));
  a_r2_step_3_6: assert property (@(posedge clk) disable iff (rst)
    (upc_q == AW'(3) || upc_q == AW'(6)) |=> upc_q == $past(upc_q) + AW'(1));
  // R3
  a_r3_rtype_disp: assert property (@(posedge clk) disable iff (rst)
    (upc_q == AW'(1) && opcode_i == OPC_RTYPE) |=> upc_q == AW'(6));
  // R4
  a_r4_load_disp: assert property (@(posedge clk) disable iff (rst)
    (upc_q == AW'(2) && opcode_i == OPC_LOAD) |=> upc_q == AW'(3));
  // R5
  a_r5_return: assert property (@(posedge clk) disable iff (rst)
    (upc_q == AW'(4) || upc_q == AW'(5) || upc_q == AW'(7) ||
     upc_q == AW'(8) || upc_q == AW'(9)) |=> upc_q == '0);
  // R8
  a_r8_ctrl_stable: assert property (@(posedge clk) disable iff (rst)
    $stable(upc_q) |-> $stable(ctrl_o));
  // R9
  a_r9_live_range: assert property (@(posedge clk) disable iff (rst)
    upc_q < AW'(LIVE_WORDS));
endmodule

// File: tb/test_microseq_ctrl.sv
module test_microseq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic [3:0] upc;
  logic [15:0] ctrl;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [5:0] OP_R = 6'b000000, OP_J = 6'b000010, OP_BQ = 6'b000100,
                         OP_LD = 6'b100011, OP_ST = 6'b101011, OP_XX = 6'b111111;

  always #5 clk = ~clk;

  microseq_ctrl i_microseq_ctrl (
    .clk(clk), .rst(rst), .opcode_i(opcode), .upc_o(upc), .ctrl_o(ctrl)
  );

  // Expected control words from R7
  function automatic logic [15:0] exp_ctrl(input int s);
    case (s)
      0: return 16'h9410; 1: return 16'h0030; 2: return 16'h0060;
      3: return 16'h3000; 4: return 16'h0300; 5: return 16'h2800;
      6: return 16'h0048; 7: return 16'h0180; 8: return 16'h4045;
      9: return 16'h8002; default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  // Walk n micro-steps; ops[k] is driven while at path[k]; finally expect 0.
  task automatic walk(input string req, input int n,
                      input logic [5:0] ops [6], input int path [6]);
    for (int k = 0; k < n; k++) begin
      chk(req, int'(upc), path[k]);
      chk("R7", int'(ctrl), int'(exp_ctrl(path[k])));
      opcode = ops[k];
      step();
    end
    chk(req, int'(upc), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    chk("R1", int'(upc), 0);
    chk("R1", int'(ctrl), 16'h9410);
    rst = 1'b0;
  endtask

  task automatic t_rtype();   // R3 R2 R5
    walk("R3", 4, '{OP_R, OP_R, OP_R, OP_R, OP_R, OP_R}, '{0, 1, 6, 7, 0, 0});
  endtask
  task automatic t_jump();
    walk("R3", 3, '{OP_J, OP_J, OP_J, OP_J, OP_J, OP_J}, '{0, 1, 9, 0, 0, 0});
  endtask
  task automatic t_branch();
    walk("R3", 3, '{OP_BQ, OP_BQ, OP_BQ, OP_BQ, OP_BQ, OP_BQ}, '{0, 1, 8, 0, 0, 0});
  endtask
  task automatic t_load();    // R4 R2 R5
    walk("R4", 5, '{OP_LD, OP_LD, OP_LD, OP_LD, OP_LD, OP_LD}, '{0, 1, 2, 3, 4, 0});
  endtask
  task automatic t_store();
    walk("R4", 4, '{OP_ST, OP_ST, OP_ST, OP_ST, OP_ST, OP_ST}, '{0, 1, 2, 5, 0, 0});
  endtask
  task automatic t_miss_tab1();   // R6
    walk("R6", 2, '{OP_XX, OP_XX, OP_XX, OP_XX, OP_XX, OP_XX}, '{0, 1, 0, 0, 0, 0});
  endtask
  task automatic t_miss_tab2();   // R6: opcode swapped to beq before 2nd dispatch
    walk("R6", 3, '{OP_LD, OP_LD, OP_BQ, OP_BQ, OP_BQ, OP_BQ}, '{0, 1, 2, 0, 0, 0});
  endtask
  task automatic t_step_ignores_op();  // R2: junk opcode in stepping words
    walk("R2", 5, '{OP_XX, OP_LD, OP_LD, OP_XX, OP_XX, OP_XX}, '{0, 1, 2, 3, 4, 0});
    walk("R2", 4, '{OP_J, OP_R, OP_ST, OP_J, OP_J, OP_J}, '{0, 1, 6, 7, 0, 0});
  endtask
  task automatic t_ctrl_hold();   // R8
    opcode = OP_R;
    step();                        // now at 1
    chk("R8", int'(upc), 1);
    chk("R8", int'(ctrl), 16'h0030);
    opcode = OP_LD; #1;
    chk("R8", int'(ctrl), 16'h0030);
    opcode = OP_XX; #1;
    chk("R8", int'(ctrl), 16'h0030);
    opcode = OP_J;
    step(); chk("R8", int'(upc), 9);
    step(); chk("R9", int'(upc), 0);
  endtask
  task automatic t_mid_reset();   // R1 from a non-zero address
    opcode = OP_LD;
    step(); step();
    chk("R1", int'(upc), 2);
    rst = 1'b1; step();
    chk("R1", int'(upc), 0);
    step(); rst = 1'b0;
    chk("R1", int'(upc), 0);
  endtask

  initial begin
    #2;
    t_reset();
    t_rtype();
    t_jump();
    t_branch();
    t_load();
    t_store();
    t_miss_tab1();
    t_miss_tab2();
    t_step_ignores_op();
    t_ctrl_hold();
    t_mid_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule